// File: doc/BRIEF.md
# Shared Waveform Generator PWM Bank

A PWM output bank in which 33 output channels draw their waveforms from a pool of only eight programmable generators. The pool has no per-channel timers. Each generator holds a period value and a duty value, and runs a 255-step phase counter. A channel is a 4-bit routing slot: it picks a generator and has an enable. The first 16 channels drive pins directly. The other 17 feed an external serial shifter, which is not part of this block.

Software writes whole 32-bit words through a simple write port. A new generator setting is held in a shadow copy until the generator finishes its running period. A routing change, by contrast, applies on the next clock. Step timing comes from an external `tick` strobe. One phase step lasts `period` strobes, so a whole period lasts 255 × period strobes. For example, a strobe of 255 per 4 ms gives a period of period × 4 ms.

Top module: `pwm_pool`

## Requirements
- R1: After reset, every channel output is 0, every channel enable is cleared and every generator has duty 0 and period 1.
- R2: Period words are at word addresses 0 and 1. Byte j (bits [8j+7:8j]) of word k sets generator 4k+j. A value of 0 is stored as 1 and a value above 250 is stored as 250. With duty d and period p, a waveform repeats every 255·p tick strobes.
- R3: Duty words are at word addresses 2 to 5. Bits [16j+7:16j] of word 2+k set the duty of generator 2k+j, and the upper byte of each 16-bit half is ignored. The output is high for the first d·p strobes of each period. Duty 0 is constant low and duty 255 is constant high.
- R4: A new period or duty value written to a generator takes effect only at that generator's next period boundary. Until then the running period completes with the old values.
- R5: Channel slots are 4 bits each, with the generator select in bits [2:0] and the enable in bit 3. Slot s of a map word occupies bits [4s+3:4s]. Channels 0–15 are in words 6 and 7 (channel c in word 6+c/8, slot c%8). Channels 16–32 are in words 8 to 10 (channel c in word 8+(c−16)/8, slot (c−16)%8).
- R6: A changed generator select, or a cleared enable, shows at the channel output on the first clock after the write. A disabled channel is low.
- R7: Generators advance only on clocks with `tick` high. While `tick` is low, every output holds its level.
- R8: Writes to word addresses 11 to 15 change no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Step strobe, one clock wide per step unit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 32 | Word written |
| ch_out | output | 33 | Channel outputs; bit c is channel c |

## Verification
Routing writes are due on the first sampled cycle after the write edge. The bench checks them at the falling edge right after its write task returns. Generator writes have no fixed delay: they land at the next period boundary. The bench therefore synchronises on a rising output edge, lets one full period pass, and only then counts high and total cycles against d·p and 255·p. The hold-over rule is checked by writing in the middle of a period, where the old and new duty disagree, and sampling before the boundary.

// File: rtl/pwm_pool_pkg.sv
package pwm_pool_pkg;

    localparam int STEPS          = 255;   // phase steps per period
    localparam int PRD_CEIL       = 250;   // largest period value kept
    localparam int WORD_W         = 32;
    localparam int SLOT_W         = 4;     // select + enable
    localparam int SLOTS_PER_WORD = WORD_W / SLOT_W;
    localparam int PRD_PER_WORD   = WORD_W / 8;
    localparam int DUTY_PER_WORD  = WORD_W / 16;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    // period limiter applied when a value enters the shadow copy
    function automatic logic [7:0] clamp_prd(input logic [7:0] v);
        if (v == 8'd0)
            return 8'd1;
        else if (v > 8'(PRD_CEIL))
            return 8'(PRD_CEIL);
        else
            return v;
    endfunction

    // word address holding the routing slot of channel c
    function automatic int slot_word(input int c, input int ndir,
                                     input int dir_base, input int ser_base);
        if (c < ndir)
            return dir_base + c / SLOTS_PER_WORD;
        else
            return ser_base + (c - ndir) / SLOTS_PER_WORD;
    endfunction

    // slot position of channel c inside its word
    function automatic int slot_pos(input int c, input int ndir);
        if (c < ndir)
            return c % SLOTS_PER_WORD;
        else
            return (c - ndir) % SLOTS_PER_WORD;
    endfunction

endpackage

// File: rtl/pwm_pool_regs.sv
module pwm_pool_regs
    import pwm_pool_pkg::*;
#(
    parameter int NUM_GEN = 8,
    parameter int NUM_DIR = 16,
    parameter int NUM_SER = 17,
    parameter int ADDR_W  = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [ADDR_W-1:0]                      wr_addr,
    input  logic [WORD_W-1:0]                      wr_data,
    output logic [NUM_GEN-1:0][7:0]                prd_sh,
    output logic [NUM_GEN-1:0][7:0]                duty_sh,
    output logic [NUM_DIR+NUM_SER-1:0][$clog2(NUM_GEN)-1:0] chan_sel,
    output logic [NUM_DIR+NUM_SER-1:0]             chan_en
);

    localparam int NUM_CH     = NUM_DIR + NUM_SER;
    localparam int SEL_W      = $clog2(NUM_GEN);
    localparam int PRD_BASE   = 0;
    localparam int PRD_WORDS  = ceil_div(NUM_GEN, PRD_PER_WORD);
    localparam int DUTY_BASE  = PRD_BASE + PRD_WORDS;
    localparam int DUTY_WORDS = ceil_div(NUM_GEN, DUTY_PER_WORD);
    localparam int DIR_BASE   = DUTY_BASE + DUTY_WORDS;
    localparam int DIR_WORDS  = ceil_div(NUM_DIR, SLOTS_PER_WORD);
    localparam int SER_BASE   = DIR_BASE + DIR_WORDS;

    typedef struct packed {
        logic [NUM_GEN-1:0][7:0]     prd;
        logic [NUM_GEN-1:0][7:0]     duty;
        logic [NUM_CH-1:0][SEL_W-1:0] sel;
        logic [NUM_CH-1:0]           en;
    } regs_t;

    localparam regs_t REGS_RST = '{
        prd:  {NUM_GEN{8'd1}},
        duty: '0,
        sel:  '0,
        en:   '0
    };

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int g = 0; g < NUM_GEN; g++) begin
                if (int'(wr_addr) == PRD_BASE + g / PRD_PER_WORD)
                    st_d.prd[g] = clamp_prd(wr_data[8*(g % PRD_PER_WORD) +: 8]);
                if (int'(wr_addr) == DUTY_BASE + g / DUTY_PER_WORD)
                    st_d.duty[g] = wr_data[16*(g % DUTY_PER_WORD) +: 8];
            end
            for (int c = 0; c < NUM_CH; c++) begin
                if (int'(wr_addr) == slot_word(c, NUM_DIR, DIR_BASE, SER_BASE)) begin
                    st_d.sel[c] = wr_data[SLOT_W*slot_pos(c, NUM_DIR) +: SEL_W];
                    st_d.en[c]  = wr_data[SLOT_W*slot_pos(c, NUM_DIR) + SLOT_W - 1];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= REGS_RST;
        else
            st_q <= st_d;
    end

    assign prd_sh   = st_q.prd;
    assign duty_sh  = st_q.duty;
    assign chan_sel = st_q.sel;
    assign chan_en  = st_q.en;

endmodule

// File: rtl/pwm_pool_gen.sv
module pwm_pool_gen
    import pwm_pool_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [7:0] prd_sh,
    input  logic [7:0] duty_sh,
    output logic       wave,
    output logic [7:0] cur_prd,
    output logic [7:0] cur_duty,
    output logic [7:0] cur_phase
);

    typedef struct packed {
        logic [7:0] pre;    // strobes inside the current step
        logic [7:0] phase;  // step inside the period
        logic [7:0] prd;    // period in force
        logic [7:0] duty;   // duty in force
    } gen_t;

    localparam gen_t GEN_RST = '{pre: 8'd0, phase: 8'd0, prd: 8'd1, duty: 8'd0};

    gen_t gs_d, gs_q;
    logic step_end;
    logic period_end;

    always_comb begin
        gs_d       = gs_q;
        step_end   = (gs_q.pre == gs_q.prd - 8'd1);
        period_end = step_end && (gs_q.phase == 8'(STEPS - 1));
        if (tick) begin
            if (step_end) begin
                gs_d.pre = 8'd0;
                if (period_end) begin
                    gs_d.phase = 8'd0;
                    gs_d.prd   = prd_sh;
                    gs_d.duty  = duty_sh;
                end else begin
                    gs_d.phase = gs_q.phase + 8'd1;
                end
            end else begin
                gs_d.pre = gs_q.pre + 8'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gs_q <= GEN_RST;
        else
            gs_q <= gs_d;
    end

    assign wave      = (gs_q.phase < gs_q.duty);
    assign cur_prd   = gs_q.prd;
    assign cur_duty  = gs_q.duty;
    assign cur_phase = gs_q.phase;

endmodule

// File: rtl/pwm_pool_route.sv
module pwm_pool_route #(
    parameter int NUM_GEN = 8,
    parameter int NUM_CH  = 33
) (
    input  logic [NUM_GEN-1:0]                    gen_wave,
    input  logic [NUM_CH-1:0][$clog2(NUM_GEN)-1:0] chan_sel,
    input  logic [NUM_CH-1:0]                     chan_en,
    output logic [NUM_CH-1:0]                     ch_out
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_out[c] = chan_en[c] & gen_wave[chan_sel[c]];
    end

endmodule

// File: rtl/pwm_pool.sv
module pwm_pool
    import pwm_pool_pkg::*;
#(
    parameter int NUM_GEN = 8,
    parameter int NUM_DIR = 16,
    parameter int NUM_SER = 17,
    parameter int ADDR_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [31:0]                wr_data,
    output logic [NUM_DIR+NUM_SER-1:0] ch_out
);

    localparam int NUM_CH = NUM_DIR + NUM_SER;
    localparam int SEL_W  = $clog2(NUM_GEN);

    logic [NUM_GEN-1:0][7:0]      prd_sh;
    logic [NUM_GEN-1:0][7:0]      duty_sh;
    logic [NUM_CH-1:0][SEL_W-1:0] chan_sel;
    logic [NUM_CH-1:0]            chan_en;
    logic [NUM_GEN-1:0]           gen_wave;
    logic [NUM_GEN-1:0][7:0]      gen_prd;
    logic [NUM_GEN-1:0][7:0]      gen_duty;
    logic [NUM_GEN-1:0][7:0]      gen_phase;

    pwm_pool_regs #(
        .NUM_GEN (NUM_GEN),
        .NUM_DIR (NUM_DIR),
        .NUM_SER (NUM_SER),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .prd_sh   (prd_sh),
        .duty_sh  (duty_sh),
        .chan_sel (chan_sel),
        .chan_en  (chan_en)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        pwm_pool_gen u_gen (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .prd_sh    (prd_sh[g]),
            .duty_sh   (duty_sh[g]),
            .wave      (gen_wave[g]),
            .cur_prd   (gen_prd[g]),
            .cur_duty  (gen_duty[g]),
            .cur_phase (gen_phase[g])
        );
    end

    pwm_pool_route #(
        .NUM_GEN (NUM_GEN),
        .NUM_CH  (NUM_CH)
    ) u_route (
        .gen_wave (gen_wave),
        .chan_sel (chan_sel),
        .chan_en  (chan_en),
        .ch_out   (ch_out)
    );

endmodule

// File: rtl/pwm_pool_chk.sv
module pwm_pool_chk #(
    parameter int NUM_GEN = 8,
    parameter int NUM_CH  = 33
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     tick,
    input logic [NUM_CH-1:0]        ch_out,
    input logic [NUM_CH-1:0]        chan_en,
    input logic [NUM_GEN-1:0]       gen_wave,
    input logic [NUM_GEN-1:0][7:0]  gen_prd,
    input logic [NUM_GEN-1:0][7:0]  gen_duty,
    input logic [NUM_GEN-1:0][7:0]  gen_phase
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_chk
        // R6: a disabled channel stays low
        a_r6_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
            !chan_en[c] |-> !ch_out[c]);
    end

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen_chk
        // R3: duty 0 is a constant low level
        a_r3_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
            (gen_duty[g] == 8'd0) |-> !gen_wave[g]);
        // R3: duty 255 is a constant high level
        a_r3_full_high: assert property (@(posedge clk) disable iff (!rst_n)
            (gen_duty[g] == 8'd255) |-> gen_wave[g]);
        // R2: the period in force is always inside 1..250
        a_r2_prd_range: assert property (@(posedge clk) disable iff (!rst_n)
            (gen_prd[g] >= 8'd1) && (gen_prd[g] <= 8'd250));
        // R2: the phase never reaches 255
        a_r2_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
            gen_phase[g] != 8'd255);
        // R4: duty in force only changes at a period start
        a_r4_duty_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(gen_duty[g]) |-> (gen_phase[g] == 8'd0));
        // R4: period in force only changes at a period start
        a_r4_prd_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(gen_prd[g]) |-> (gen_phase[g] == 8'd0));
        // R7: no step without a strobe
        a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(tick) |-> $stable(gen_phase[g]));
    end

endmodule

bind pwm_pool pwm_pool_chk #(
    .NUM_GEN (NUM_GEN),
    .NUM_CH  (NUM_CH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .ch_out    (ch_out),
    .chan_en   (chan_en),
    .gen_wave  (gen_wave),
    .gen_prd   (gen_prd),
    .gen_duty  (gen_duty),
    .gen_phase (gen_phase)
);

// File: tb/sim_pwm_pool.sv
module sim_pwm_pool;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [32:0] ch_out;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] prd_w [2];
    logic [31:0] duty_w [4];
    logic [31:0] map_w [5];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_pool u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ch_out  (ch_out)
    );

    function automatic int exp_prd(input int v);
        if (v == 0) return 1;
        if (v > 250) return 250;
        return v;
    endfunction

    function automatic int exp_high(input int d, input int p);
        return d * exp_prd(p);
    endfunction

    function automatic int exp_period(input int p);
        return 255 * exp_prd(p);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 4'(addr);
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic set_prd(input int g, input int v);
        prd_w[g/4][8*(g%4) +: 8] = 8'(v);
        wr(g/4, prd_w[g/4]);
    endtask

    task automatic set_duty(input int g, input int d);
        duty_w[g/2][16*(g%2) +: 16] = {8'(255 - d), 8'(d)};
        wr(2 + g/2, duty_w[g/2]);
    endtask

    task automatic set_map(input int c, input int sel, input bit en);
        int w;
        int s;
        w = (c < 16) ? c/8 : 2 + (c-16)/8;
        s = (c < 16) ? c%8 : (c-16)%8;
        map_w[w][4*s +: 4] = {en, 3'(sel)};
        wr(6 + w, map_w[w]);
    endtask

    // returns at the first sample in which channel ch is high after being low
    task automatic wait_rise(input int ch);
        logic prev;
        prev = ch_out[ch];
        @(negedge clk);
        while (!( !prev && ch_out[ch])) begin
            prev = ch_out[ch];
            @(negedge clk);
        end
    endtask

    // starts at a rising sample, returns at the next rising sample
    task automatic run_period(input int ch, output int hi, output int per);
        hi = 0;
        while (ch_out[ch]) begin
            hi++;
            @(negedge clk);
        end
        per = hi;
        while (!ch_out[ch]) begin
            per++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R4 watchdog actual=%0d expected=completion", WD_CYCLES);
        finish_run();
    end

    initial begin
        int hi;
        int per;
        int bad;
        logic [17:0] snap;
        void'($urandom(32'd1234));
        prd_w[0] = 32'h01010101;
        prd_w[1] = 32'h01010101;
        for (int i = 0; i < 4; i++) duty_w[i] = '0;
        for (int i = 0; i < 5; i++) map_w[i] = '0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, all channels low
        check(ch_out == '0, "R1", int'(ch_out[31:0]), 0);

        // R3, R5: constant high on generator 6, constant low on generator 7
        set_duty(6, 255);
        set_duty(7, 0);
        repeat (300) @(negedge clk);
        set_map(15, 6, 1'b1);
        set_map(16, 7, 1'b1);
        set_map(32, 6, 1'b1);
        check(ch_out[15] == 1'b1, "R5 ch15 word7 slot7", int'(ch_out[15]), 1);
        check(ch_out[16] == 1'b0, "R5 ch16 word8 slot0", int'(ch_out[16]), 0);
        check(ch_out[32] == 1'b1, "R5 ch32 word10 slot0", int'(ch_out[32]), 1);
        bad = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (ch_out[15] != 1'b1 || ch_out[16] != 1'b0) bad++;
        end
        check(bad == 0, "R3 duty 255 high, duty 0 low", bad, 0);

        // R6: select switch and enable clear apply on the next clock
        set_map(16, 6, 1'b1);
        check(ch_out[16] == 1'b1, "R6 select switch", int'(ch_out[16]), 1);
        set_map(16, 6, 1'b0);
        check(ch_out[16] == 1'b0, "R6 enable clear", int'(ch_out[16]), 0);

        // R8: unmapped addresses leave every setting alone
        snap = ch_out[32:15];
        wr(11, 32'hFFFF_FFFF);
        wr(15, 32'hFFFF_FFFF);
        repeat (5) @(negedge clk);
        check(ch_out[32:15] == snap, "R8 unmapped write", int'(ch_out[32:15]), int'(snap));

        // R4: mid-period duty change waits for the boundary
        set_prd(5, 1);
        set_duty(5, 50);
        set_map(17, 5, 1'b1);
        wait_rise(17);
        run_period(17, hi, per);
        run_period(17, hi, per);
        check(hi == exp_high(50, 1), "R3 duty 50 high time", hi, exp_high(50, 1));
        repeat (99) @(negedge clk);
        set_duty(5, 200);
        check(ch_out[17] == 1'b0, "R4 old duty holds", int'(ch_out[17]), 0);
        wait_rise(17);
        run_period(17, hi, per);
        check(hi == exp_high(200, 1), "R4 new duty after boundary", hi, exp_high(200, 1));
        check(per == exp_period(1), "R2 period 1", per, exp_period(1));

        // R7: without strobes the output level holds
        tick = 1'b0;
        bad = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (ch_out[17] != 1'b1) bad++;
        end
        check(bad == 0, "R7 frozen without tick", bad, 0);
        tick = 1'b1;

        // R2, R3: random generators, periods and channels
        for (int it = 0; it < 6; it++) begin
            int g;
            int p;
            int d;
            int c;
            g = int'($urandom % 5);
            p = 1 + int'($urandom % 3);
            d = 1 + int'($urandom % 254);
            c = int'($urandom % 15);
            set_prd(g, p);
            set_duty(g, d);
            set_map(c, g, 1'b1);
            wait_rise(c);
            run_period(c, hi, per);
            run_period(c, hi, per);
            check(hi == exp_high(d, p), "R3 random high time", hi, exp_high(d, p));
            check(per == exp_period(p), "R2 random period", per, exp_period(p));
        end

        // R2: period 0 is treated as 1
        set_prd(5, 0);
        set_duty(5, 30);
        wait_rise(17);
        run_period(17, hi, per);
        run_period(17, hi, per);
        check(hi == exp_high(30, 0), "R2 period 0 high time", hi, exp_high(30, 0));
        check(per == exp_period(0), "R2 period 0 length", per, exp_period(0));

        // R2: period 255 is limited to 250
        set_prd(5, 255);
        set_duty(5, 1);
        wait_rise(17);
        hi = 0;
        while (ch_out[17]) begin
            hi++;
            @(negedge clk);
        end
        check(hi == exp_high(1, 255), "R2 period clamp", hi, exp_high(1, 255));

        finish_run();
    end

endmodule